// File: doc/BRIEF.md
# Asynchronous Single-Strobe Host Read Port

This block sits on the slave side of a parallel host bus. An external host reads from it by asserting a chip select and driving the read/write line high. It then pulls one or more byte strobes low. The port brings every host input into the local clock domain through two-flop synchronizers and finds the strobe edges on the synchronized copies. On a falling strobe edge that belongs to a read, it latches the word address and the chip identifier. The access goes ahead only if that identifier equals the configured device number.

An accepted access fetches one word over a single-outstanding internal request/response port. The port then drives the word onto the data bus and pulls the active-low acknowledge low. The host completes the access by raising its strobes. After the strobes rise, acknowledge is either released to high impedance at once or driven high for a programmed number of clocks. The port models each tri-state pin as a value plus an output enable.

Reads to the memory half of the address space can start a prefetch of the following word into a one-entry buffer. A later read that hits that buffer is acknowledged sooner than a read that misses it. Chip select may stay asserted across consecutive reads.

Top module: `host_read_port`

## Requirements
- R1: After reset, the data-bus enable, the acknowledge enable and the internal request are all low.
- R2: A read whose chip identifier differs from `cfg_dev_id` never enables the data bus or the acknowledge, and it issues no internal request.
- R3: An access starts only on a falling strobe edge while chip select is low and `h_rnw` is 1. A strobe with `h_rnw` at 0 causes no drive and no request.
- R4: The acknowledge is driven low only while the data-bus enable is high and the bus carries the word that the internal port returned for the latched address.
- R5: Address bit AW-1 set selects the register space. Such a read returns the internal port's word for that address and never starts a prefetch.
- R6: With `cfg_pf_en` at 1, a memory read issues one further request for the next word address (bit AW-1 clear, lower bits plus one). A following read to that address hits the buffer, is acknowledged in fewer cycles than a miss, and issues no demand request. At most one internal request is outstanding at any time.
- R7: The buffer is emptied by a register read, by a memory read to any address other than the buffered one, and by `cfg_pf_en` at 0. A read after any of these takes the miss latency.
- R8: The data-bus enable drops in the same cycle that the rising strobe edge is detected. With `cfg_ack_drive` at 0 or `cfg_ack_time` at 00, the acknowledge enable drops in that same cycle.
- R9: With `cfg_ack_drive` at 1, `cfg_ack_time` values 01, 10 and 11 drive the acknowledge high for 1, 2 and 4 clocks, counted from the strobe-rise detection cycle. The acknowledge is then released. It is never driven high under any other setting.
- R10: Consecutive reads with chip select held low are each served. A falling strobe edge detected while the acknowledge is still being driven high ends the high drive early and starts the new access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_dev_id | input | IDW | Device number that the host chip identifier must match |
| cfg_pf_en | input | 1 | Enables sequential prefetch for memory reads |
| cfg_ack_drive | input | 1 | Enables active high drive of acknowledge after the strobe rises |
| cfg_ack_time | input | 2 | High-drive length code (00 none, 01 one, 10 two, 11 four clocks) |
| h_cs_n | input | 1 | Host chip select, active low |
| h_rnw | input | 1 | Host read (1) / write (0) |
| h_bs_n | input | DW/8 | Host byte strobes, active low |
| h_id | input | IDW | Host chip identifier |
| h_addr | input | AW | Host word address; MSB selects register space |
| h_data | output | DW | Read data toward the host |
| h_data_oe | output | 1 | Data-bus output enable |
| h_ack_n | output | 1 | Acknowledge value, active low |
| h_ack_oe | output | 1 | Acknowledge output enable |
| mem_req | output | 1 | One-cycle internal read request |
| mem_addr | output | AW | Internal read address |
| mem_vld | input | 1 | Internal read response strobe |
| mem_rdata | input | DW | Internal read response data |

## Verification
The two functions that can coincide are the acknowledge high-drive countdown and the detection of a new access. They meet when the host drops its strobe again soon after raising it, with the longest drive code selected. The bench holds the strobe high for only two clocks, so the new falling edge is seen while the countdown is still running. It then checks three things: fewer than four high-drive cycles were seen, the second read returns the correct word, and the second read is acknowledged normally.

// File: rtl/hrp_pkg.sv
package hrp_pkg;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_LOOK  = 3'd1,
    ST_FETCH = 3'd2,
    ST_DRIVE = 3'd3,
    ST_HOLD  = 3'd4
  } hrp_state_e;

  localparam int HOLD_W = 3;

  // Drive-high length in clocks for a code; 0 means release only.
  function automatic logic [HOLD_W-1:0] hold_cycles(input logic [1:0] code);
    case (code)
      2'b01:   hold_cycles = 3'd1;
      2'b10:   hold_cycles = 3'd2;
      2'b11:   hold_cycles = 3'd4;
      default: hold_cycles = 3'd0;
    endcase
  endfunction

endpackage

// File: rtl/hrp_sync.sv
module hrp_sync #(
  parameter int         W   = 8,
  parameter logic [W-1:0] RST = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_async,
  output logic [W-1:0] q_sync
);

  logic [W-1:0] meta_q;
  logic [W-1:0] sync_q;

  for (genvar i = 0; i < W; i++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        meta_q[i] <= RST[i];
        sync_q[i] <= RST[i];
      end else begin
        meta_q[i] <= d_async[i];
        sync_q[i] <= meta_q[i];
      end
    end
  end

  assign q_sync = sync_q;

endmodule

// File: rtl/hrp_pfbuf.sv
module hrp_pfbuf #(
  parameter int AW = 12,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          launch,
  input  logic [AW-1:0] launch_addr,
  input  logic          inv,
  input  logic [AW-1:0] look_addr,
  input  logic          mem_vld,
  input  logic [DW-1:0] mem_rdata,
  output logic          req,
  output logic [AW-1:0] req_addr,
  output logic          busy,
  output logic          hit,
  output logic [DW-1:0] hit_data
);

  logic          pend_q, pend_d;
  logic          out_q,  out_d;
  logic          vld_q,  vld_d;
  logic [AW-1:0] tgt_q,  tgt_d;
  logic [AW-1:0] badr_q, badr_d;
  logic [DW-1:0] bdat_q, bdat_d;
  logic          fill_en;

  assign fill_en = out_q && mem_vld;

  always_comb begin
    pend_d = pend_q;
    out_d  = out_q;
    vld_d  = vld_q;
    tgt_d  = tgt_q;
    badr_d = badr_q;
    bdat_d = bdat_q;
    if (pend_q) begin
      pend_d = 1'b0;
      out_d  = 1'b1;
    end
    if (fill_en) begin
      out_d  = 1'b0;
      vld_d  = en;
      badr_d = tgt_q;
      bdat_d = mem_rdata;
    end
    if (launch) begin
      pend_d = 1'b1;
      tgt_d  = launch_addr;
      vld_d  = 1'b0;
    end
    if (inv || !en) begin
      vld_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      out_q  <= 1'b0;
      vld_q  <= 1'b0;
      tgt_q  <= '0;
      badr_q <= '0;
      bdat_q <= '0;
    end else begin
      pend_q <= pend_d;
      out_q  <= out_d;
      vld_q  <= vld_d;
      if (launch) tgt_q <= tgt_d;
      if (fill_en) begin
        badr_q <= badr_d;
        bdat_q <= bdat_d;
      end
    end
  end

  assign req      = pend_q;
  assign req_addr = tgt_q;
  assign busy     = pend_q || out_q;
  assign hit      = vld_q && (badr_q == look_addr);
  assign hit_data = bdat_q;

endmodule

// File: rtl/host_read_port.sv
module host_read_port
  import hrp_pkg::*;
#(
  parameter int AW  = 12,
  parameter int DW  = 32,
  parameter int IDW = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [IDW-1:0]  cfg_dev_id,
  input  logic            cfg_pf_en,
  input  logic            cfg_ack_drive,
  input  logic [1:0]      cfg_ack_time,
  input  logic            h_cs_n,
  input  logic            h_rnw,
  input  logic [DW/8-1:0] h_bs_n,
  input  logic [IDW-1:0]  h_id,
  input  logic [AW-1:0]   h_addr,
  output logic [DW-1:0]   h_data,
  output logic            h_data_oe,
  output logic            h_ack_n,
  output logic            h_ack_oe,
  output logic            mem_req,
  output logic [AW-1:0]   mem_addr,
  input  logic            mem_vld,
  input  logic [DW-1:0]   mem_rdata
);

  localparam int NBS = DW / 8;
  localparam int SW  = 2 + NBS + IDW + AW;
  localparam logic [SW-1:0] SYNC_RST = {1'b1, 1'b0, {NBS{1'b1}}, {(IDW + AW){1'b0}}};

  // Synchronized host inputs
  logic [SW-1:0]  sync_in, sync_out;
  logic           cs_n_s, rnw_s;
  logic [NBS-1:0] bs_n_s;
  logic [IDW-1:0] id_s;
  logic [AW-1:0]  addr_s;

  assign sync_in = {h_cs_n, h_rnw, h_bs_n, h_id, h_addr};

  hrp_sync #(.W(SW), .RST(SYNC_RST)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .d_async (sync_in),
    .q_sync  (sync_out)
  );

  assign {cs_n_s, rnw_s, bs_n_s, id_s, addr_s} = sync_out;

  // Strobe edge detection
  logic bs_act, bs_act_q, bs_fall, bs_rise, start, id_hit;

  assign bs_act  = ~&bs_n_s;
  assign bs_fall = bs_act && !bs_act_q;
  assign bs_rise = !bs_act && bs_act_q;
  assign start   = bs_fall && !cs_n_s && rnw_s;
  assign id_hit  = (id_s == cfg_dev_id);

  // Access state
  hrp_state_e        state_q, state_d;
  logic [AW-1:0]     addr_q, addr_d;
  logic [DW-1:0]     data_q, data_d;
  logic [HOLD_W-1:0] cnt_q, cnt_d;
  logic              addr_en, data_en, cnt_en;

  logic              is_reg, dem_req, launch, inv;
  logic [AW-1:0]     next_addr;
  logic              pf_req, pf_busy, pf_hit;
  logic [AW-1:0]     pf_addr;
  logic [DW-1:0]     pf_data;
  logic [HOLD_W-1:0] hold_len;
  logic              hold_on;

  assign is_reg    = addr_q[AW-1];
  assign next_addr = {1'b0, addr_q[AW-2:0] + {{(AW-2){1'b0}}, 1'b1}};
  assign hold_len  = hold_cycles(cfg_ack_time);
  assign hold_on   = cfg_ack_drive && (hold_len != '0);

  hrp_pfbuf #(.AW(AW), .DW(DW)) u_pf (
    .clk         (clk),
    .rst_n       (rst_n),
    .en          (cfg_pf_en),
    .launch      (launch),
    .launch_addr (next_addr),
    .inv         (inv),
    .look_addr   (addr_q),
    .mem_vld     (mem_vld),
    .mem_rdata   (mem_rdata),
    .req         (pf_req),
    .req_addr    (pf_addr),
    .busy        (pf_busy),
    .hit         (pf_hit),
    .hit_data    (pf_data)
  );

  always_comb begin
    state_d = state_q;
    addr_d  = addr_q;
    data_d  = data_q;
    cnt_d   = cnt_q;
    dem_req = 1'b0;
    launch  = 1'b0;
    inv     = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (start && id_hit) begin
          addr_d  = addr_s;
          state_d = ST_LOOK;
        end
      end
      ST_LOOK: begin
        if (!pf_busy) begin
          if (is_reg || !(cfg_pf_en && pf_hit)) begin
            inv     = 1'b1;
            dem_req = 1'b1;
            state_d = ST_FETCH;
          end else begin
            data_d  = pf_data;
            launch  = 1'b1;
            state_d = ST_DRIVE;
          end
        end
      end
      ST_FETCH: begin
        if (mem_vld) begin
          data_d  = mem_rdata;
          launch  = cfg_pf_en && !is_reg;
          state_d = ST_DRIVE;
        end
      end
      ST_DRIVE: begin
        if (bs_rise) begin
          if (hold_on && (hold_len > 3'd1)) begin
            cnt_d   = hold_len - 3'd1;
            state_d = ST_HOLD;
          end else begin
            state_d = ST_IDLE;
          end
        end
      end
      ST_HOLD: begin
        if (start && id_hit) begin
          addr_d  = addr_s;
          state_d = ST_LOOK;
        end else if (cnt_q <= 3'd1) begin
          state_d = ST_IDLE;
        end else begin
          cnt_d = cnt_q - 3'd1;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  assign addr_en = (addr_d != addr_q);
  assign data_en = (state_q == ST_LOOK) || (state_q == ST_FETCH);
  assign cnt_en  = (state_q == ST_DRIVE) || (state_q == ST_HOLD);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      addr_q   <= '0;
      data_q   <= '0;
      cnt_q    <= '0;
      bs_act_q <= 1'b0;
    end else begin
      state_q  <= state_d;
      bs_act_q <= bs_act;
      if (addr_en) addr_q <= addr_d;
      if (data_en) data_q <= data_d;
      if (cnt_en)  cnt_q  <= cnt_d;
    end
  end

  // Host-side drive
  logic in_drive, in_hold;
  assign in_drive = (state_q == ST_DRIVE);
  assign in_hold  = (state_q == ST_HOLD);

  assign h_data    = data_q;
  assign h_data_oe = in_drive && !bs_rise;
  assign h_ack_n   = !(in_drive && !bs_rise);
  assign h_ack_oe  = (in_drive && (!bs_rise || hold_on)) || in_hold;

  // Internal port
  assign mem_req  = dem_req || pf_req;
  assign mem_addr = pf_req ? pf_addr : addr_q;

endmodule

// File: rtl/hrp_chk.sv
module hrp_chk #(
  parameter int AW = 12,
  parameter int DW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cfg_ack_drive,
  input logic [1:0]    cfg_ack_time,
  input logic          h_data_oe,
  input logic          h_ack_n,
  input logic          h_ack_oe,
  input logic          mem_req,
  input logic [AW-1:0] mem_addr,
  input logic          mem_vld,
  input logic [DW-1:0] mem_rdata
);

  logic       outst_q;
  logic [2:0] hi_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      outst_q <= 1'b0;
      hi_q    <= '0;
    end else begin
      if (mem_req)      outst_q <= 1'b1;
      else if (mem_vld) outst_q <= 1'b0;
      if (h_ack_oe && h_ack_n) hi_q <= (hi_q == 3'd7) ? hi_q : hi_q + 3'd1;
      else                     hi_q <= '0;
    end
  end

  // R4
  ack_with_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (h_ack_oe && !h_ack_n) |-> h_data_oe);

  // R8
  ack_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(h_data_oe) && (!cfg_ack_drive || cfg_ack_time == 2'b00)) |-> !h_ack_oe);

  // R9
  high_cfg_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (h_ack_oe && h_ack_n) |-> (cfg_ack_drive && cfg_ack_time != 2'b00));

  // R9
  high_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (h_ack_oe && h_ack_n) |-> (hi_q < 3'd4));

  // R6
  single_outst_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> !outst_q);

  logic unused_ok;
  assign unused_ok = ^{mem_addr, mem_rdata};

endmodule

bind host_read_port hrp_chk #(.AW(AW), .DW(DW)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .cfg_ack_drive (cfg_ack_drive),
  .cfg_ack_time  (cfg_ack_time),
  .h_data_oe     (h_data_oe),
  .h_ack_n       (h_ack_n),
  .h_ack_oe      (h_ack_oe),
  .mem_req       (mem_req),
  .mem_addr      (mem_addr),
  .mem_vld       (mem_vld),
  .mem_rdata     (mem_rdata)
);

// File: tb/sim_host_read_port.sv
module sim_host_read_port;

  localparam int AW  = 12;
  localparam int DW  = 32;
  localparam int IDW = 4;
  localparam int NBS = DW / 8;
  localparam logic [IDW-1:0] MY_ID = 4'h9;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [IDW-1:0]  cfg_dev_id = MY_ID;
  logic            cfg_pf_en = 1'b0;
  logic            cfg_ack_drive = 1'b0;
  logic [1:0]      cfg_ack_time = 2'b00;
  logic            h_cs_n = 1'b1;
  logic            h_rnw = 1'b1;
  logic [NBS-1:0]  h_bs_n = '1;
  logic [IDW-1:0]  h_id = '0;
  logic [AW-1:0]   h_addr = '0;
  logic [DW-1:0]   h_data;
  logic            h_data_oe, h_ack_n, h_ack_oe;
  logic            mem_req;
  logic [AW-1:0]   mem_addr;
  logic            mem_vld = 1'b0;
  logic [DW-1:0]   mem_rdata = '0;

  always #2 clk = ~clk;

  host_read_port #(.AW(AW), .DW(DW), .IDW(IDW)) u0 (
    .clk(clk), .rst_n(rst_n),
    .cfg_dev_id(cfg_dev_id), .cfg_pf_en(cfg_pf_en),
    .cfg_ack_drive(cfg_ack_drive), .cfg_ack_time(cfg_ack_time),
    .h_cs_n(h_cs_n), .h_rnw(h_rnw), .h_bs_n(h_bs_n), .h_id(h_id), .h_addr(h_addr),
    .h_data(h_data), .h_data_oe(h_data_oe), .h_ack_n(h_ack_n), .h_ack_oe(h_ack_oe),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_vld(mem_vld), .mem_rdata(mem_rdata)
  );

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 0;

  function automatic logic [DW-1:0] model_word(input logic [AW-1:0] a);
    model_word = (a[AW-1] ? 32'hA5A50000 : 32'h5A5A0000) | {20'b0, a};
  endfunction

  // Internal memory model: 3-negedge response latency
  int            m_nreq = 0;
  logic [AW-1:0] m_last = '0;
  logic [AW-1:0] m_addr = '0;
  bit            m_busy = 0;
  int            m_cd   = 0;
  always @(negedge clk) begin
    mem_vld <= 1'b0;
    if (m_busy) begin
      if (m_cd == 0) begin
        mem_vld   <= 1'b1;
        mem_rdata <= model_word(m_addr);
        m_busy    <= 0;
      end else m_cd <= m_cd - 1;
    end
    if (rst_n && mem_req) begin
      m_busy <= 1;
      m_cd   <= 2;
      m_addr <= mem_addr;
      m_last <= mem_addr;
      m_nreq <= m_nreq + 1;
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // One host read; returns data, latency to ack, high-drive cycles and release sample
  task automatic do_read(input logic [AW-1:0] a, output logic [DW-1:0] d,
                         output int lat, output int hi, output bit got, output bit rel_ok);
    @(negedge clk);
    h_addr = a; h_id = MY_ID; h_cs_n = 1'b0; h_rnw = 1'b1;
    @(negedge clk);
    h_bs_n = '0;
    lat = 0; got = 0; hi = 0; rel_ok = 0; d = '0;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      lat++;
      if (h_ack_oe && !h_ack_n) begin
        got = h_data_oe;
        d = h_data;
        break;
      end
    end
    h_bs_n = '1;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (!(h_ack_oe && !h_ack_n)) break;
    end
    rel_ok = !h_data_oe;
    for (int i = 0; i < 10; i++) begin
      if (!(h_ack_oe && h_ack_n)) break;
      hi++;
      @(negedge clk);
    end
    repeat (10) @(negedge clk);
  endtask

  task automatic t_reset();
    @(negedge clk);
    check(!h_data_oe && !h_ack_oe && !mem_req, "R1 reset outputs",
          {h_data_oe, h_ack_oe, mem_req}, 0);
  endtask

  task automatic strobe_quiet(input logic [IDW-1:0] id, input logic rnw, input string tag);
    int n0;
    bit seen;
    n0 = m_nreq; seen = 0;
    @(negedge clk);
    h_addr = 12'h012; h_id = id; h_cs_n = 1'b0; h_rnw = rnw;
    @(negedge clk);
    h_bs_n = '0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (h_data_oe || h_ack_oe) seen = 1;
    end
    h_bs_n = '1;
    repeat (6) @(negedge clk);
    check(!seen, tag, seen, 0);
    check(m_nreq == n0, tag, m_nreq - n0, 0);
    h_rnw = 1'b1;
  endtask

  int miss_lat = 0;

  task automatic t_plain();
    logic [DW-1:0] d; int lat, hi, n0; bit got, rel;
    cfg_pf_en = 0; n0 = m_nreq;
    do_read(12'h010, d, lat, hi, got, rel);
    miss_lat = lat;
    check(got, "R4 ack with data_oe", got, 1);
    check(d == model_word(12'h010), "R4 data", d, model_word(12'h010));
    check(rel, "R8 data_oe drops at release", rel, 1);
    check(hi == 0, "R8 ack released", hi, 0);
    check(m_nreq - n0 == 1, "R6 no prefetch when disabled", m_nreq - n0, 1);
  endtask

  task automatic t_prefetch();
    logic [DW-1:0] d; int lat, hi, n0; bit got, rel;
    cfg_pf_en = 1; n0 = m_nreq;
    do_read(12'h020, d, lat, hi, got, rel);
    check(m_nreq - n0 == 2, "R6 prefetch issued", m_nreq - n0, 2);
    check(m_last == 12'h021, "R6 prefetch address", m_last, 12'h021);
    n0 = m_nreq;
    do_read(12'h021, d, lat, hi, got, rel);
    check(d == model_word(12'h021), "R6 hit data", d, model_word(12'h021));
    check(lat < miss_lat, "R6 hit faster than miss", lat, miss_lat);
    check(m_nreq - n0 == 1 && m_last == 12'h022, "R6 only next prefetch", m_last, 12'h022);
  endtask

  task automatic t_invalidate();
    logic [DW-1:0] d; int lat, hi, n0; bit got, rel;
    cfg_pf_en = 1;
    do_read(12'h030, d, lat, hi, got, rel);
    do_read(12'h040, d, lat, hi, got, rel);
    check(d == model_word(12'h040), "R7 non-consecutive data", d, model_word(12'h040));
    check(lat >= miss_lat, "R7 non-consecutive misses", lat, miss_lat);
    n0 = m_nreq;
    do_read(12'h805, d, lat, hi, got, rel);
    check(d == model_word(12'h805), "R5 register data", d, model_word(12'h805));
    check(m_nreq - n0 == 1, "R5 no prefetch on register read", m_nreq - n0, 1);
    do_read(12'h041, d, lat, hi, got, rel);
    check(lat >= miss_lat, "R7 register read empties buffer", lat, miss_lat);
    do_read(12'h060, d, lat, hi, got, rel);
    cfg_pf_en = 0;
    repeat (2) @(negedge clk);
    do_read(12'h061, d, lat, hi, got, rel);
    check(lat >= miss_lat, "R7 disable empties buffer", lat, miss_lat);
    check(d == model_word(12'h061), "R7 data after disable", d, model_word(12'h061));
  endtask

  task automatic t_hold(input logic drv, input logic [1:0] code, input int exp_hi);
    logic [DW-1:0] d; int lat, hi; bit got, rel;
    cfg_ack_drive = drv; cfg_ack_time = code;
    do_read(12'h070, d, lat, hi, got, rel);
    check(hi == exp_hi, "R9 high-drive length", hi, exp_hi);
    check(rel, "R8 data_oe drops at release", rel, 1);
  endtask

  task automatic t_b2b();
    int hi; bit got; logic [DW-1:0] d;
    cfg_ack_drive = 1; cfg_ack_time = 2'b11; cfg_pf_en = 0;
    @(negedge clk);
    h_addr = 12'h100; h_id = MY_ID; h_cs_n = 1'b0; h_rnw = 1'b1;
    @(negedge clk);
    h_bs_n = '0;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (h_ack_oe && !h_ack_n) break;
    end
    check(h_data == model_word(12'h100), "R10 first data", h_data, model_word(12'h100));
    h_bs_n = '1;
    h_addr = 12'h101;
    @(negedge clk);
    @(negedge clk);
    h_bs_n = '0;
    hi = 0; got = 0; d = '0;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (h_ack_oe && h_ack_n) hi++;
      if (h_ack_oe && !h_ack_n) begin got = 1; d = h_data; break; end
    end
    check(hi >= 1 && hi < 4, "R10 high drive cut short", hi, 3);
    check(got && d == model_word(12'h101), "R10 second data", d, model_word(12'h101));
    check(!h_cs_n, "R10 chip select held", h_cs_n, 0);
    h_bs_n = '1;
    repeat (12) @(negedge clk);
    h_cs_n = 1'b1;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    strobe_quiet(4'h3, 1'b1, "R2 id mismatch ignored");
    strobe_quiet(MY_ID, 1'b0, "R3 write strobe ignored");
    t_plain();
    t_prefetch();
    t_invalidate();
    t_hold(1'b1, 2'b01, 1);
    t_hold(1'b1, 2'b10, 2);
    t_hold(1'b1, 2'b11, 4);
    t_hold(1'b0, 2'b10, 0);
    t_hold(1'b1, 2'b00, 0);
    t_b2b();
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

endmodule